// File: doc/BRIEF.md
# Character Display Cursor Address and Scroll Offset Unit

This unit holds the cursor address and the horizontal scroll position of a two-line character display controller. The address points into display memory, where character codes are kept, or into pattern memory, where custom glyphs are kept. After every data transfer the unit moves the address by one position. It also services cursor-move and scroll commands and direct address loads. The scroll position is held as an offset that both lines share.

In two-line mode the first line uses addresses 0x00 to 0x27 and the second line uses 0x40 to 0x67. Stepping past the end of one line continues on the other line, so the cursor never rests in the unused gap between them. In one-line mode the range is a single run from 0x00 to 0x4F. Addresses in pattern memory are six bits wide. Their upper three bits pick one of eight glyphs and their lower three bits pick a row. The unit also outputs the display-memory address shown in every visible column of both lines, which the refresh logic uses. Command decoding and the memories themselves are outside this unit.

Top module: `dd_cursor_ctrl`

## Requirements
- R1: After reset the address is 0x00, display memory is selected and the scroll offset is 0.
- R2: A load with `load_cg`=0 selects display memory and takes all 7 address bits. A load with `load_cg`=1 selects pattern memory and takes bits 5..0, so address bit 6 reads 0.
- R3: A data access (`acc_stb`) steps the address by one: up when `inc_dir`=1, down when `inc_dir`=0.
- R4: In two-line display-memory mode an up-step goes from 0x27 to 0x40 and from 0x67 to 0x00. A down-step goes from 0x40 to 0x27 and from 0x00 to 0x67. From a gap address (0x28-0x3F) an up-step gives 0x40 and a down-step gives 0x27. From above 0x67 an up-step gives 0x00 and a down-step gives 0x67.
- R5: In one-line display-memory mode an up-step goes from 0x4F or above to 0x00. A down-step goes from 0x00, or from above 0x4F, to 0x4F.
- R6: In pattern-memory mode every step wraps modulo 64, and the address stays below 0x40.
- R7: A cursor move (`shift_stb` with `shift_sc`=0) steps the address up when `shift_rl`=1 and down when `shift_rl`=0. It uses the wrap rules of R4 to R6 and leaves the offset unchanged.
- R8: A scroll (`shift_stb` with `shift_sc`=1) leaves the address unchanged. With `shift_rl`=0 it scrolls left, so the offset rises by 1 and wraps from 39 to 0. With `shift_rl`=1 it scrolls right, so the offset falls by 1 and wraps from 0 to 39.
- R9: A display-memory write with `shift_en`=1 also scrolls: left when `inc_dir`=1 and right when `inc_dir`=0. Reads, pattern-memory accesses and writes with `shift_en`=0 leave the offset unchanged.
- R10: When strobes arrive in the same cycle, a load overrides a shift command, and a shift command overrides a data access. Only the winning strobe acts.
- R11: In two-line mode, `col_addr[c*7 +: 7]` is (c+offset) mod 40 and `col_addr[(16+c)*7 +: 7]` is 0x40 plus that value. In one-line mode the first slot is (c+offset) mod 80 and the second-line slots are 0.
- R12: Each update takes effect on the clock edge after its strobe. `col_addr` follows the offset and `two_line` without any further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_stb | input | 1 | Data read or write took place |
| acc_wr | input | 1 | 1 = the access was a write |
| shift_stb | input | 1 | Cursor-move or scroll command |
| shift_sc | input | 1 | 1 = scroll display, 0 = move cursor |
| shift_rl | input | 1 | 1 = right, 0 = left |
| load_stb | input | 1 | Direct address load |
| load_cg | input | 1 | 1 = load pattern-memory address |
| load_addr | input | 7 | Address to load |
| inc_dir | input | 1 | Entry direction, 1 = increment |
| shift_en | input | 1 | Scroll on display-memory writes |
| two_line | input | 1 | 1 = two-line layout |
| ac_addr | output | 7 | Current address |
| ac_is_cg | output | 1 | Pattern memory selected |
| disp_ofs | output | 6 | Scroll offset, 0 to 39 |
| col_addr | output | 224 | Per-column display address, line 1 then line 2 |

## Verification
The bench drives the address onto each line end, into the 0x28-0x3F gap and above 0x67, then steps it in both directions in both layouts. A design that steps linearly would leave the cursor in unused memory or send it back to the wrong line. The bench wraps the offset through 39 and 0 in both directions; an offset that is not wrapped would map columns to addresses past the line. It also mixes writes, reads and pattern-memory accesses with scrolling enabled, because a design that scrolls on every access would scroll on reads. Finally, it raises several strobes in one cycle, where a wrong priority moves the address and the offset together.

// File: rtl/dd_pkg.sv
package dd_pkg;
    localparam int AW  = 7;
    localparam int CGW = AW - 1;
endpackage

// File: rtl/dd_addr_step.sv
module dd_addr_step
    import dd_pkg::*;
#(
    parameter int LINE_LEN   = 40,
    parameter int LINE2_BASE = 64
) (
    input  logic [AW-1:0] cur,
    input  logic          is_cg,
    input  logic          two_line,
    input  logic          up,
    output logic [AW-1:0] nxt
);
    localparam logic [AW-1:0] L1_END  = AW'(LINE_LEN - 1);
    localparam logic [AW-1:0] L2_BASE = AW'(LINE2_BASE);
    localparam logic [AW-1:0] L2_END  = AW'(LINE2_BASE + LINE_LEN - 1);
    localparam logic [AW-1:0] ONE_END = AW'(2 * LINE_LEN - 1);

    logic in_gap;
    assign in_gap = (cur > L1_END) && (cur < L2_BASE);

    always_comb begin
        if (is_cg) begin
            nxt = {1'b0, up ? cur[CGW-1:0] + 1'b1 : cur[CGW-1:0] - 1'b1};
        end else if (two_line) begin
            if (up) begin
                if (cur == L1_END || in_gap) nxt = L2_BASE;
                else if (cur >= L2_END)      nxt = '0;
                else                         nxt = cur + 1'b1;
            end else begin
                if (cur == '0)                    nxt = L2_END;
                else if (cur == L2_BASE || in_gap) nxt = L1_END;
                else if (cur > L2_END)            nxt = L2_END;
                else                              nxt = cur - 1'b1;
            end
        end else begin
            if (up) nxt = (cur >= ONE_END) ? '0 : cur + 1'b1;
            else    nxt = (cur == '0 || cur > ONE_END) ? ONE_END : cur - 1'b1;
        end
    end
endmodule

// File: rtl/dd_ofs_step.sv
module dd_ofs_step #(
    parameter int LINE_LEN = 40,
    parameter int OW       = $clog2(LINE_LEN)
) (
    input  logic [OW-1:0] cur,
    input  logic          left,
    output logic [OW-1:0] nxt
);
    localparam logic [OW-1:0] LAST = OW'(LINE_LEN - 1);

    always_comb begin
        if (left) nxt = (cur >= LAST) ? '0 : cur + 1'b1;
        else      nxt = (cur == '0) ? LAST : cur - 1'b1;
    end
endmodule

// File: rtl/dd_col_map.sv
module dd_col_map
    import dd_pkg::*;
#(
    parameter int COLS       = 16,
    parameter int LINE_LEN   = 40,
    parameter int LINE2_BASE = 64,
    parameter int OW         = $clog2(LINE_LEN)
) (
    input  logic [OW-1:0]        ofs,
    input  logic                 two_line,
    output logic [2*COLS*AW-1:0] col_addr
);
    localparam int SW = AW + 1;

    for (genvar c = 0; c < COLS; c++) begin : g_col
        logic [SW-1:0] sum;
        logic [AW-1:0] v_l1;
        logic [AW-1:0] v_l2;
        assign sum = SW'(c) + SW'(ofs);

        always_comb begin
            if (two_line) begin
                v_l1 = (sum >= SW'(LINE_LEN)) ? AW'(sum - SW'(LINE_LEN)) : AW'(sum);
                v_l2 = v_l1 + AW'(LINE2_BASE);
            end else begin
                v_l1 = (sum >= SW'(2 * LINE_LEN)) ? AW'(sum - SW'(2 * LINE_LEN)) : AW'(sum);
                v_l2 = '0;
            end
        end

        assign col_addr[c*AW +: AW]        = v_l1;
        assign col_addr[(COLS+c)*AW +: AW] = v_l2;
    end
endmodule

// File: rtl/dd_cursor_ctrl.sv
module dd_cursor_ctrl
    import dd_pkg::*;
#(
    parameter int COLS       = 16,
    parameter int LINE_LEN   = 40,
    parameter int LINE2_BASE = 64,
    parameter int OW         = $clog2(LINE_LEN)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_stb,
    input  logic                 acc_wr,
    input  logic                 shift_stb,
    input  logic                 shift_sc,
    input  logic                 shift_rl,
    input  logic                 load_stb,
    input  logic                 load_cg,
    input  logic [AW-1:0]        load_addr,
    input  logic                 inc_dir,
    input  logic                 shift_en,
    input  logic                 two_line,
    output logic [AW-1:0]        ac_addr,
    output logic                 ac_is_cg,
    output logic [OW-1:0]        disp_ofs,
    output logic [2*COLS*AW-1:0] col_addr
);
    localparam logic [AW-1:0] L1_END  = AW'(LINE_LEN - 1);
    localparam logic [AW-1:0] L2_BASE = AW'(LINE2_BASE);
    localparam logic [AW-1:0] L2_END  = AW'(LINE2_BASE + LINE_LEN - 1);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          cg;
        logic [OW-1:0] ofs;
    } cur_state_t;

    cur_state_t st_d, st_q;

    logic          step_up;
    logic          scroll_left;
    logic [AW-1:0] addr_stepped;
    logic [OW-1:0] ofs_stepped;

    // Direction source: a shift command uses R/L, otherwise the entry direction.
    assign step_up     = shift_stb ? shift_rl  : inc_dir;
    assign scroll_left = shift_stb ? ~shift_rl : inc_dir;

    dd_addr_step #(.LINE_LEN(LINE_LEN), .LINE2_BASE(LINE2_BASE)) u_step (
        .cur      (st_q.addr),
        .is_cg    (st_q.cg),
        .two_line (two_line),
        .up       (step_up),
        .nxt      (addr_stepped)
    );

    dd_ofs_step #(.LINE_LEN(LINE_LEN), .OW(OW)) u_ofs (
        .cur  (st_q.ofs),
        .left (scroll_left),
        .nxt  (ofs_stepped)
    );

    dd_col_map #(.COLS(COLS), .LINE_LEN(LINE_LEN), .LINE2_BASE(LINE2_BASE), .OW(OW)) u_map (
        .ofs      (st_q.ofs),
        .two_line (two_line),
        .col_addr (col_addr)
    );

    always_comb begin
        st_d = st_q;
        if (load_stb) begin
            st_d.cg   = load_cg;
            st_d.addr = load_cg ? {1'b0, load_addr[CGW-1:0]} : load_addr;
        end else if (shift_stb) begin
            if (shift_sc) st_d.ofs  = ofs_stepped;
            else          st_d.addr = addr_stepped;
        end else if (acc_stb) begin
            st_d.addr = addr_stepped;
            if (acc_wr && shift_en && !st_q.cg) st_d.ofs = ofs_stepped;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ac_addr  = st_q.addr;
    assign ac_is_cg = st_q.cg;
    assign disp_ofs = st_q.ofs;

    // R4: a step in two-line display mode never lands in the gap or above line two
    a_r4_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_stb && two_line && !ac_is_cg &&
         ((shift_stb && !shift_sc) || (acc_stb && !shift_stb)))
        |=> (ac_addr <= L1_END || (ac_addr >= L2_BASE && ac_addr <= L2_END)));

    // R8: scrolling holds the address
    a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_stb && shift_sc && !load_stb) |=> $stable(ac_addr));

    // R8: offset stays inside one line
    a_r8_ofs_range: assert property (@(posedge clk) disable iff (!rst_n)
        disp_ofs < OW'(LINE_LEN));

    // R9: reads never scroll
    a_r9_read_no_scroll: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_stb && !acc_wr && !shift_stb && !load_stb) |=> $stable(disp_ofs));

    // R6: pattern-memory address stays below 0x40
    a_r6_cg_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        ac_is_cg |-> !ac_addr[AW-1]);

    // R2: a pattern-memory load selects pattern memory
    a_r2_cg_select: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && load_cg) |=> ac_is_cg);
endmodule

// File: tb/tb_dd_cursor_ctrl.sv
`timescale 1ns/1ps
module tb_dd_cursor_ctrl;
    localparam int COLS = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_stb = 0, acc_wr = 0, shift_stb = 0, shift_sc = 0, shift_rl = 0;
    logic load_stb = 0, load_cg = 0, inc_dir = 1, shift_en = 0, two_line = 1;
    logic [6:0] load_addr = '0;
    logic [6:0] ac_addr;
    logic       ac_is_cg;
    logic [5:0] disp_ofs;
    logic [2*COLS*7-1:0] col_addr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    int m_addr = 0;
    bit m_cg   = 0;
    int m_ofs  = 0;

    always #5 clk = ~clk;

    dd_cursor_ctrl dut (
        .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .acc_wr(acc_wr),
        .shift_stb(shift_stb), .shift_sc(shift_sc), .shift_rl(shift_rl),
        .load_stb(load_stb), .load_cg(load_cg), .load_addr(load_addr),
        .inc_dir(inc_dir), .shift_en(shift_en), .two_line(two_line),
        .ac_addr(ac_addr), .ac_is_cg(ac_is_cg), .disp_ofs(disp_ofs), .col_addr(col_addr)
    );

    function automatic int f_step(int a, bit cg, bit two, bit up);
        if (cg) return up ? ((a + 1) % 64) : ((a + 63) % 64);
        if (two) begin
            if (up) begin
                if (a >= 39 && a < 64) return 64;
                if (a >= 103) return 0;
                return a + 1;
            end
            if (a == 0) return 103;
            if (a > 39 && a <= 64) return 39;
            if (a > 103) return 103;
            return a - 1;
        end
        if (up) return (a >= 79) ? 0 : a + 1;
        return (a == 0 || a > 79) ? 79 : a - 1;
    endfunction

    function automatic int f_scroll(int o, bit left);
        return left ? ((o + 1) % 40) : ((o + 39) % 40);
    endfunction

    function automatic int f_col(int c, int o, bit two, bit line2);
        if (two) return ((c + o) % 40) + (line2 ? 64 : 0);
        return line2 ? 0 : ((c + o) % 80);
    endfunction

    task automatic chk(string tag, int got, int exp, string what);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic check_all(string tag);
        bit colbad = 0;
        int bad_c = 0, bad_g = 0, bad_e = 0;
        chk(tag, int'(ac_addr), m_addr, "address");
        chk(tag, int'(ac_is_cg), int'(m_cg), "pattern select");
        chk(tag, int'(disp_ofs), m_ofs, "offset");
        for (int c = 0; c < 2 * COLS; c++) begin
            int e = f_col(c % COLS, m_ofs, two_line, c >= COLS);
            int g = int'(col_addr[c*7 +: 7]);
            if (g != e && !colbad) begin colbad = 1; bad_c = c; bad_g = g; bad_e = e; end
        end
        n_tests++;
        if (colbad) begin
            n_fail++;
            $display("FAIL R11 (%s) column slot %0d: got %0h expected %0h", tag, bad_c, bad_g, bad_e);
        end
    endtask

    task automatic cyc(string tag, bit ld, bit lcg, int la, bit sh, bit sc, bit rl,
                       bit ac, bit wr, bit id, bit sen, bit two);
        load_stb = ld; load_cg = lcg; load_addr = 7'(la);
        shift_stb = sh; shift_sc = sc; shift_rl = rl;
        acc_stb = ac; acc_wr = wr; inc_dir = id; shift_en = sen; two_line = two;
        if (ld) begin
            m_cg = lcg;
            m_addr = lcg ? (la % 64) : la;
        end else if (sh) begin
            if (sc) m_ofs = f_scroll(m_ofs, !rl);
            else    m_addr = f_step(m_addr, m_cg, two, rl);
        end else if (ac) begin
            m_addr = f_step(m_addr, m_cg, two, id);
            if (wr && sen && !m_cg) m_ofs = f_scroll(m_ofs, id);
        end
        @(posedge clk);
        @(negedge clk);
        load_stb = 0; shift_stb = 0; acc_stb = 0;
        check_all(tag);
    endtask

    task automatic ld(string tag, int a, bit cg, bit two);
        cyc(tag, 1, cg, a, 0, 0, 0, 0, 0, 1, 0, two);
    endtask

    task automatic acc(string tag, bit wr, bit id, bit sen, bit two);
        cyc(tag, 0, 0, 0, 0, 0, 0, 1, wr, id, sen, two);
    endtask

    task automatic shf(string tag, bit sc, bit rl, bit two);
        cyc(tag, 0, 0, 0, 1, sc, rl, 0, 0, 1, 0, two);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4321));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");

        // R2 / R3 / R4 two-line wraps
        ld("R2 load", 7'h27, 0, 1);
        acc("R4 0x27 up", 1, 1, 0, 1);
        chk("R4", int'(ac_addr), 64, "0x27+1");
        ld("R2 load", 7'h67, 0, 1);
        acc("R4 0x67 up", 0, 1, 0, 1);
        acc("R4 0x00 down", 0, 0, 0, 1);
        ld("R2 load", 7'h40, 0, 1);
        acc("R4 0x40 down", 1, 0, 0, 1);
        acc("R3 down", 1, 0, 0, 1);
        ld("R2 gap", 7'h30, 0, 1);
        acc("R4 gap up", 0, 1, 0, 1);
        ld("R2 gap", 7'h30, 0, 1);
        acc("R4 gap down", 0, 0, 0, 1);
        ld("R2 high", 7'h70, 0, 1);
        acc("R4 high up", 0, 1, 0, 1);
        ld("R2 high", 7'h70, 0, 1);
        acc("R4 high down", 0, 0, 0, 1);

        // R5 one-line wraps
        ld("R2 load", 7'h4F, 0, 0);
        acc("R5 0x4F up", 1, 1, 0, 0);
        acc("R5 0x00 down", 1, 0, 0, 0);
        ld("R2 load", 7'h60, 0, 0);
        acc("R5 above up", 0, 1, 0, 0);
        ld("R2 load", 7'h60, 0, 0);
        acc("R5 above down", 0, 0, 0, 0);

        // R6 pattern memory
        ld("R2 cg load", 7'h7F, 1, 1);
        chk("R2", int'(ac_addr), 63, "cg load bit6 clear");
        acc("R6 cg up", 1, 1, 1, 1);
        acc("R6 cg down", 1, 0, 1, 1);
        chk("R9", int'(disp_ofs), 0, "cg write no scroll");
        shf("R7 cg cursor right", 0, 1, 1);

        // R7 cursor moves
        ld("R2 ddram back", 7'h27, 0, 1);
        shf("R7 right", 0, 1, 1);
        shf("R7 left", 0, 0, 1);
        shf("R7 left", 0, 0, 1);

        // R8 scrolls
        shf("R8 right from 0", 1, 1, 1);
        chk("R8", int'(disp_ofs), 39, "right wrap");
        for (int i = 0; i < 41; i++) shf("R8 left", 1, 0, 1);
        check_all("R11 one-line view");
        two_line = 0; #1;
        check_all("R11 one-line view");
        two_line = 1; #1;

        // R9 write-driven scroll
        ld("R2 load", 7'h05, 0, 1);
        acc("R9 write scroll left", 1, 1, 1, 1);
        acc("R9 write scroll right", 1, 0, 1, 1);
        acc("R9 read no scroll", 0, 1, 1, 1);
        acc("R9 write sh off", 1, 1, 0, 1);

        // R10 priority
        cyc("R10 load wins", 1, 0, 7'h10, 1, 1, 0, 1, 1, 1, 1, 1);
        cyc("R10 shift wins", 0, 0, 0, 1, 1, 0, 1, 1, 1, 1, 1);
        cyc("R10 cursor over acc", 0, 0, 0, 1, 0, 1, 1, 1, 0, 1, 1);

        // Random mix (R3..R11)
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom % 16;
            bit two = ($urandom % 8) != 0;
            if (r < 2) begin
                int pick = $urandom % 8;
                int la = (pick == 0) ? 7'h27 : (pick == 1) ? 7'h40 : (pick == 2) ? 7'h67 :
                         (pick == 3) ? 7'h4F : (pick == 4) ? 7'h00 : int'($urandom % 128);
                cyc("R2 rnd load", 1, ($urandom % 4) == 0, la, $urandom % 2, $urandom % 2, 0,
                    $urandom % 2, 0, 1, 0, two);
            end else if (r < 5) begin
                cyc("R7/R8 rnd shift", 0, 0, 0, 1, $urandom % 2, $urandom % 2,
                    $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, two);
            end else if (r < 13) begin
                cyc("R3/R9 rnd access", 0, 0, 0, 0, 0, 0, 1, $urandom % 2,
                    $urandom % 2, $urandom % 2, two);
            end else begin
                cyc("R12 rnd idle", 0, 0, 0, 0, 0, 0, 0, 0, $urandom % 2, $urandom % 2, two);
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule